// File: doc/BRIEF.md
# Circular Buffer Word Writer

This block accepts a stream of 32-bit words and stores them, one after another, in a region of host memory that it treats as a ring. Each word goes to the region's base address plus a running byte offset. The offset moves forward by four bytes once the memory port has accepted the write. When the offset reaches the end of the region, it returns to zero.

The block raises a one-cycle interrupt at two points: when the first half of the region has been filled, and when the second half has been filled and writing wraps back to the start. A status bit is latched with each interrupt and tells the host which half has just become complete. The host can then drain that half while the writer fills the other half.

The base address and the region length in bytes are sampled while reset is held. They stay fixed from then until the next reset. The length must be a multiple of 8 bytes, so that each half holds a whole number of words.

Top module: `ring_word_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `inReady` is 1, `memStrobe` is 0, `irqPulse` is 0 and `irqSecondHalf` is 0. The first word after reset is written at the base address.
- R2: For each accepted word, starting in the cycle after acceptance, `memStrobe` is 1, `memAddr` equals base plus the current offset, and `memData` equals the word. Address and data hold steady until the cycle in which `memReady` is 1.
- R3: From the cycle after a word is accepted until the cycle after `memReady` completes its write, `inReady` is 0. Every accepted word produces exactly one memory write.
- R4: The offset moves forward by 4 bytes only on the edge where `memStrobe` and `memReady` are both 1. While the memory port stalls, the offset does not change.
- R5: When the advanced offset equals half the region length, `irqPulse` is 1 in the cycle after the memory accepts the write and `irqSecondHalf` becomes 0. The next word goes to the following address, with no wrap.
- R6: When the advanced offset equals the region length, `irqPulse` is 1 in the cycle after the memory accepts the write and `irqSecondHalf` becomes 1. The next word goes to the base address.
- R7: `irqSecondHalf` keeps its value between interrupts. It changes only in a cycle where `irqPulse` is 1.
- R8: Changes to `cfgBase` or `cfgSizeBytes` after reset has been released have no effect on addresses or interrupt points.
- R9: `irqPulse` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; configuration is sampled while it is low |
| cfgBase | input | 32 | Byte address of the start of the region |
| cfgSizeBytes | input | 32 | Region length in bytes, a multiple of 8 |
| inValid | input | 1 | Input word is present |
| inData | input | 32 | Input word |
| inReady | output | 1 | Writer can take a word |
| memStrobe | output | 1 | Write request to memory |
| memAddr | output | 32 | Write byte address |
| memData | output | 32 | Write data |
| memReady | input | 1 | Memory accepts the current write |
| irqPulse | output | 1 | One-cycle interrupt at the half mark and at the end mark |
| irqSecondHalf | output | 1 | Which half was just completed: 0 for the first, 1 for the second |

## Verification
A wrong offset shows on `memAddr` in the cycle after the next word is accepted. A wrong region length or half mark shows as an interrupt that is missing or misplaced within one pass through the ring. Offset movement during a stall shows as a skipped address on the following write. A word that is lost or written twice shows up because the bench pairs each word it sends with exactly one write and one address.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic take;    // a word is accepted from the input
    logic commit;  // the memory port accepts the pending write
  } cbwStrobe_t;

endpackage

// File: rtl/cbw_ctrl.sv
module cbw_ctrl
  import cbw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       memReady,
  output logic       inReady,
  output logic       memStrobe,
  output cbwStrobe_t strobes
);

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } cbwState_t;

  cbwState_t state;
  cbwState_t stateNext;

  always_comb begin
    stateNext      = state;
    strobes.take   = 1'b0;
    strobes.commit = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          strobes.take = 1'b1;
          stateNext    = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (memReady) begin
          strobes.commit = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady   = (state == ST_IDLE);
  assign memStrobe = (state == ST_BUSY);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memStrobe && !memReady) |=> (memStrobe && !inReady));

  // R3
  single_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> !strobes.take);

endmodule

// File: rtl/cbw_path.sv
module cbw_path
  import cbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgSizeBytes,
  input  logic [DATA_W-1:0] inData,
  input  cbwStrobe_t        strobes,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              irqPulse,
  output logic              irqSecondHalf
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] sizeReg;
  logic [ADDR_W-1:0] offsetReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              irqReg;
  logic              halfReg;

  logic [ADDR_W-1:0] offsetNext;
  logic [ADDR_W-1:0] halfMark;
  logic              hitEnd;
  logic              hitHalf;

  assign offsetNext = offsetReg + STEP;
  assign halfMark   = sizeReg >> 1;
  assign hitEnd     = (offsetNext == sizeReg);
  assign hitHalf    = (offsetNext == halfMark);

  // Configuration is held while reset is low and then frozen.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= cfgBase;
      sizeReg <= cfgSizeBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetReg <= '0;
      irqReg    <= 1'b0;
      halfReg   <= 1'b0;
    end else begin
      irqReg <= strobes.commit && (hitEnd || hitHalf);
      if (strobes.commit) begin
        if (hitEnd) begin
          offsetReg <= '0;
          halfReg   <= 1'b1;
        end else begin
          offsetReg <= offsetNext;
          if (hitHalf) halfReg <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else if (strobes.take) begin
      addrReg <= baseReg + offsetReg;
      dataReg <= inData;
    end
  end

  assign memAddr       = addrReg;
  assign memData       = dataReg;
  assign irqPulse      = irqReg;
  assign irqSecondHalf = halfReg;

  // R4
  offset_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    offsetReg[ALIGN_BITS-1:0] == '0);

  // R4
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(offsetReg));

  // R6
  offset_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeReg >= 2 * STEP) |-> (offsetReg < sizeReg));

  // R7
  half_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReg |=> (irqReg || $stable(halfReg)));

endmodule

// File: rtl/ring_word_writer.sv
module ring_word_writer
  import cbw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cfgBase,
  input  logic [31:0] cfgSizeBytes,
  input  logic        inValid,
  input  logic [31:0] inData,
  output logic        inReady,
  output logic        memStrobe,
  output logic [31:0] memAddr,
  output logic [31:0] memData,
  input  logic        memReady,
  output logic        irqPulse,
  output logic        irqSecondHalf
);

  cbwStrobe_t strobes;

  cbw_ctrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .memReady  (memReady),
    .inReady   (inReady),
    .memStrobe (memStrobe),
    .strobes   (strobes)
  );

  cbw_path #(
    .ADDR_W (32),
    .DATA_W (32)
  ) path (
    .clk           (clk),
    .rstN          (rstN),
    .cfgBase       (cfgBase),
    .cfgSizeBytes  (cfgSizeBytes),
    .inData        (inData),
    .strobes       (strobes),
    .memAddr       (memAddr),
    .memData       (memData),
    .irqPulse      (irqPulse),
    .irqSecondHalf (irqSecondHalf)
  );

  // R2
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memStrobe && !memReady) |=> (memStrobe && $stable(memAddr) && $stable(memData)));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(memStrobe && memReady));

endmodule

// File: tb/ring_word_writer_test.sv
module ring_word_writer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [31:0] cfgSizeBytes = '0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        memStrobe;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        memReady = 1'b0;
  logic        irqPulse;
  logic        irqSecondHalf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic expHalf = 1'b0;

  always #2 clk = ~clk;

  ring_word_writer uut (
    .clk           (clk),
    .rstN          (rstN),
    .cfgBase       (cfgBase),
    .cfgSizeBytes  (cfgSizeBytes),
    .inValid       (inValid),
    .inData        (inData),
    .inReady       (inReady),
    .memStrobe     (memStrobe),
    .memAddr       (memAddr),
    .memData       (memData),
    .memReady      (memReady),
    .irqPulse      (irqPulse),
    .irqSecondHalf (irqSecondHalf)
  );

  // Ring of 32 bytes at 0x1000: half mark after word 3, end mark after word 7.
  // Irq codes: 0 none, 1 first half done, 2 second half done.
  localparam int NV = 12;
  localparam logic [31:0] TBL_DATA [NV] = '{
    32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h8000_0001, 32'h7FFF_FFFE,
    32'hCAFE_F00D, 32'h0000_00FF, 32'h5555_AAAA, 32'h3C3C_C3C3};
  localparam int TBL_WAIT [NV] = '{0, 2, 0, 1, 3, 0, 0, 5, 1, 0, 2, 0};
  localparam logic [31:0] TBL_ADDR [NV] = '{
    32'h1000, 32'h1004, 32'h1008, 32'h100C,
    32'h1010, 32'h1014, 32'h1018, 32'h101C,
    32'h1000, 32'h1004, 32'h1008, 32'h100C};
  localparam logic [1:0] TBL_IRQ [NV] = '{0, 0, 0, 1, 0, 0, 0, 2, 0, 0, 0, 1};

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [31:0] base, input logic [31:0] size);
    @(negedge clk);
    rstN = 1'b0;
    cfgBase = base;
    cfgSizeBytes = size;
    inValid = 1'b0;
    memReady = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 inReady in reset", {31'd0, inReady}, 32'd1);
    check("R1 memStrobe in reset", {31'd0, memStrobe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 inReady after reset", {31'd0, inReady}, 32'd1);
    check("R1 irqPulse after reset", {31'd0, irqPulse}, 32'd0);
    check("R1 irqSecondHalf after reset", {31'd0, irqSecondHalf}, 32'd0);
    expHalf = 1'b0;
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic sendWord(input logic [31:0] d, input int waitCyc,
                          input logic [31:0] expAddr, input logic [1:0] expIrq);
    check("R3 inReady before word", {31'd0, inReady}, 32'd1);
    inValid = 1'b1;
    inData = d;
    @(negedge clk);
    inValid = 1'b0;
    inData = ~d;
    check("R2 memStrobe", {31'd0, memStrobe}, 32'd1);
    check("R2 memAddr", memAddr, expAddr);
    check("R2 memData", memData, d);
    check("R3 inReady busy", {31'd0, inReady}, 32'd0);
    for (int k = 0; k < waitCyc; k++) begin
      @(negedge clk);
      check("R2 stall memStrobe", {31'd0, memStrobe}, 32'd1);
      check("R4 stall memAddr", memAddr, expAddr);
      check("R2 stall memData", memData, d);
      check("R3 stall inReady", {31'd0, inReady}, 32'd0);
    end
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
    if (expIrq == 2'd1) expHalf = 1'b0;
    if (expIrq == 2'd2) expHalf = 1'b1;
    check(expIrq == 2'd2 ? "R6 irqPulse" : "R5 irqPulse",
          {31'd0, irqPulse}, {31'd0, expIrq != 2'd0});
    check("R7 irqSecondHalf", {31'd0, irqSecondHalf}, {31'd0, expHalf});
    check("R3 memStrobe released", {31'd0, memStrobe}, 32'd0);
    check("R3 inReady back", {31'd0, inReady}, 32'd1);
    @(negedge clk);
    check("R9 irqPulse one cycle", {31'd0, irqPulse}, 32'd0);
    check("R7 irqSecondHalf held", {31'd0, irqSecondHalf}, {31'd0, expHalf});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset(32'h1000, 32'd32);
    // R8: configuration changes after reset must be ignored.
    cfgBase = 32'h8000;
    cfgSizeBytes = 32'd16;
    for (int i = 0; i < NV; i++) begin
      sendWord(TBL_DATA[i], TBL_WAIT[i], TBL_ADDR[i], TBL_IRQ[i]);
    end

    // R6 / R5: a small 16-byte ring, with a stall on the wrapping write.
    doReset(32'h0200, 32'd16);
    sendWord(32'h1111_1111, 0, 32'h0200, 2'd0);
    sendWord(32'h2222_2222, 1, 32'h0204, 2'd1);
    sendWord(32'h3333_3333, 0, 32'h0208, 2'd0);
    sendWord(32'h4444_4444, 4, 32'h020C, 2'd2);
    sendWord(32'h5555_5555, 0, 32'h0200, 2'd0);

    // R4: an idle gap with memReady high and no word pending must not move the offset.
    memReady = 1'b1;
    repeat (3) @(negedge clk);
    memReady = 1'b0;
    check("R4 no spurious irq", {31'd0, irqPulse}, 32'd0);
    sendWord(32'h6666_6666, 0, 32'h0204, 2'd1);

    // R1: the smallest ring of 8 bytes, where every write hits a mark.
    doReset(32'h0040, 32'd8);
    sendWord(32'hABCD_0000, 0, 32'h0040, 2'd1);
    sendWord(32'hABCD_0001, 0, 32'h0044, 2'd2);
    sendWord(32'hABCD_0002, 2, 32'h0040, 2'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule